// File: doc/BRIEF.md
# Keypad Sequence Door Lock

A Moore state machine that watches a two-key keypad and releases a door latch only after the three-key code B, A, B has been entered. Each key press arrives as one clock cycle with a key-valid strobe high and two identity lines that name the key. Every input is already synchronous to the clock, and a synchronous active-high reset returns the lock to its idle state.

An attempt always takes three key presses. A wrong key does not send the lock straight back to idle. It moves the lock onto a separate bad path whose states show the same running key count as the good path. So the count display never shows where the mistake was made. After the third key of a correct attempt, the lock asserts a one-cycle unlock pulse and then returns to idle on the next clock.

The running count is given two ways: as a 4-bit binary value, and as an 8-line one-hot bus for a display. All outputs depend only on the registered state.

Top module: `seq_door_lock`

## Requirements
- R1: While reset is high at a clock edge the lock goes to idle, where the count is 0, unlock is low and display line 0 alone is high.
- R2: A cycle with key_valid low holds the state, whatever key_a and key_b are. Count and unlock stay unchanged. The one exception is the code-accepted state (R10).
- R3: The key codes {key_valid,key_a,key_b} = 101 (B), then 110 (A), then 101 (B), entered from idle, give count 3 and unlock high in the cycle after the third key. Unlock is high for that one cycle only.
- R4: A first key other than B gives count 1, and any second key then gives count 2. A third key then returns the lock to idle with count 0. Unlock never rises.
- R5: After a correct first key B, a second key other than A gives count 2. Any third key then gives count 0 with no unlock.
- R6: After a correct B, A, a third key other than B returns the lock to idle (count 0) with no unlock.
- R7: The codes 100 and 111 (key_valid high with neither key, or with both keys) count as a wrong key.
- R8: count_lines is one-hot: line n is high exactly when the count equals n.
- R9: Unlock is high only while the count is 3.
- R10: In the code-accepted state the lock goes back to idle on the next clock, whether a key is pressed or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | High for one cycle per key press |
| key_a | input | 1 | Key identity line for key A |
| key_b | input | 1 | Key identity line for key B |
| unlock | output | 1 | One-cycle pulse after the correct code |
| key_count | output | 4 | Keys entered so far in this attempt, binary |
| count_lines | output | 8 | One-hot decode of key_count |

## Verification
The correct B, A, B code is entered both back to back and with idle gaps between keys. During the gaps the identity lines are toggled while key_valid stays low, to show that only the strobe matters. Wrong attempts are tried with the mistake at the first, second and third key. This shows that the count runs 1, 2, 0 the same way whichever key was wrong, and that the good path drops out at the right place. The undefined codes are fed in place of real keys to confirm they act as a wrong key. A key press during the unlock cycle shows that the unlock state always leaves after one cycle.

// File: rtl/door_lock_pkg.sv
package door_lock_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 3'b000,
        ST_G1   = 3'b001,
        ST_G2   = 3'b010,
        ST_G3   = 3'b011,
        ST_B1   = 3'b100,
        ST_B2   = 3'b101
    } lock_state_e;

    typedef enum logic [1:0] {
        KC_NONE,
        KC_A,
        KC_B,
        KC_WRONG
    } key_class_e;

    typedef struct packed {
        logic valid;
        logic a;
        logic b;
    } key_code_t;

    // Decode a raw keypad code into a key class; undefined strobed codes are wrong keys
    function automatic key_class_e classify_key(key_code_t c);
        key_class_e r;
        if (!c.valid)            r = KC_NONE;
        else if (c.a && !c.b)    r = KC_A;
        else if (!c.a && c.b)    r = KC_B;
        else                     r = KC_WRONG;
        return r;
    endfunction

    // Keys shown for each state; the bad path mirrors the good path count
    function automatic int unsigned state_count(lock_state_e s);
        int unsigned r;
        case (s)
            ST_G1, ST_B1: r = 1;
            ST_G2, ST_B2: r = 2;
            ST_G3:        r = 3;
            default:      r = 0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/key_classifier.sv
module key_classifier
    import door_lock_pkg::*;
(
    input  key_code_t  code,
    output key_class_e kclass
);
    always_comb begin
        kclass = classify_key(code);
    end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import door_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  key_class_e  kclass,
    output lock_state_e state
);
    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (kclass == KC_B)         state_d = ST_G1;
                else if (kclass != KC_NONE) state_d = ST_B1;
            end
            ST_G1: begin
                if (kclass == KC_A)         state_d = ST_G2;
                else if (kclass != KC_NONE) state_d = ST_B2;
            end
            ST_G2: begin
                if (kclass == KC_B)         state_d = ST_G3;
                else if (kclass != KC_NONE) state_d = ST_IDLE;
            end
            ST_G3:   state_d = ST_IDLE;
            ST_B1: begin
                if (kclass != KC_NONE)      state_d = ST_B2;
            end
            ST_B2: begin
                if (kclass != KC_NONE)      state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;

    // R2: no key holds the state outside the accept state
    p_hold_no_key_r2: assert property (@(posedge clk) disable iff (rst)
        (kclass == KC_NONE && state_q != ST_G3) |=> $stable(state_q));

    // R10: accept state lasts one cycle
    p_accept_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_G3) |=> (state_q == ST_IDLE));

    // R4: a wrong first key enters the bad path
    p_bad_first_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && (kclass == KC_A || kclass == KC_WRONG)) |=> (state_q == ST_B1));

    // R5: a wrong second key skips to the second bad state
    p_bad_second_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_G1 && (kclass == KC_B || kclass == KC_WRONG)) |=> (state_q == ST_B2));

    // R6: a wrong third key ends the attempt without acceptance
    p_bad_third_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_G2 && (kclass == KC_A || kclass == KC_WRONG)) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/count_display.sv
module count_display
    import door_lock_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  lock_state_e      state,
    output logic             unlock,
    output logic [CNT_W-1:0] count,
    output logic [LINES-1:0] lines
);
    localparam int ACCEPT_COUNT = 3;

    always_comb begin
        count  = CNT_W'(state_count(state));
        unlock = (state == ST_G3);
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        assign lines[n] = (count == CNT_W'(n));
    end

    // R8: display bus is one-hot
    p_lines_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot(lines));

    // R9: unlock only with the full count
    p_unlock_count_r9: assert property (@(posedge clk) disable iff (rst)
        unlock |-> (count == CNT_W'(ACCEPT_COUNT)));

    // R3: unlock is a single-cycle pulse
    p_unlock_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        unlock |=> !unlock);
endmodule

// File: rtl/seq_door_lock.sv
module seq_door_lock
    import door_lock_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic             key_a,
    input  logic             key_b,
    output logic             unlock,
    output logic [CNT_W-1:0] key_count,
    output logic [LINES-1:0] count_lines
);
    key_code_t   code;
    key_class_e  kclass;
    lock_state_e state;

    assign code = '{valid: key_valid, a: key_a, b: key_b};

    key_classifier u_classify (
        .code   (code),
        .kclass (kclass)
    );

    lock_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .kclass (kclass),
        .state  (state)
    );

    count_display #(
        .CNT_W (CNT_W),
        .LINES (LINES)
    ) u_display (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .unlock (unlock),
        .count  (key_count),
        .lines  (count_lines)
    );
endmodule

// File: tb/sim_seq_door_lock.sv
module sim_seq_door_lock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic       key_a = 1'b0;
    logic       key_b = 1'b0;
    logic       unlock;
    logic [3:0] key_count;
    logic [7:0] count_lines;

    int errors = 0;
    int checks = 0;
    int mstate = 0;   // 0 idle,1..3 good path,4..5 bad path

    always #4 clk = ~clk;

    seq_door_lock u0 (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_a(key_a), .key_b(key_b),
        .unlock(unlock), .key_count(key_count), .count_lines(count_lines)
    );

    function automatic int model_next(int s, bit k, bit a, bit b);
        int c; // 0 none,1 A,2 B,3 wrong
        int r;
        if (!k) c = 0; else if (a && !b) c = 1; else if (!a && b) c = 2; else c = 3;
        r = s;
        case (s)
            0: if (c == 2) r = 1; else if (c != 0) r = 4;
            1: if (c == 1) r = 2; else if (c != 0) r = 5;
            2: if (c == 2) r = 3; else if (c != 0) r = 0;
            3: r = 0;
            4: if (c != 0) r = 5;
            5: if (c != 0) r = 0;
            default: r = 0;
        endcase
        return r;
    endfunction

    function automatic int model_count(int s);
        case (s)
            1, 4: return 1;
            2, 5: return 2;
            3:    return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req);
        int  ec = model_count(mstate);
        bit  eu = (mstate == 3);
        logic [7:0] el = 8'(1 << ec);
        checks++;
        if (key_count !== 4'(ec) || unlock !== eu || count_lines !== el) begin
            errors++;
            $display("FAIL %s: count=%0d unlock=%0b lines=%b expected count=%0d unlock=%0b lines=%b",
                     req, key_count, unlock, count_lines, ec, eu, el);
        end
    endtask

    task automatic key(bit k, bit a, bit b, string req);
        key_valid = k; key_a = a; key_b = b;
        @(negedge clk);
        mstate = model_next(mstate, k, a, b);
        key_valid = 1'b0; key_a = 1'b0; key_b = 1'b0;
        check(req);
    endtask

    task automatic gap(int n, bit a, bit b, string req);
        for (int i = 0; i < n; i++) begin
            key_a = a; key_b = b;
            @(negedge clk);
            mstate = model_next(mstate, 1'b0, a, b);
            check(req);
        end
        key_a = 1'b0; key_b = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mstate = 0;
        check("R1 reset idle");
    endtask

    task automatic t_good_back_to_back();
        key(1, 0, 1, "R3 first B");
        key(1, 1, 0, "R3 second A");
        key(1, 0, 1, "R3 third B unlock R9");
        key(0, 0, 0, "R3 pulse ends R10");
        gap(2, 0, 0, "R2 idle hold");
    endtask

    task automatic t_good_with_gaps();
        key(1, 0, 1, "R3 gap B");
        gap(3, 1, 1, "R2 identity lines ignored");
        key(1, 1, 0, "R3 gap A");
        gap(2, 0, 1, "R2 identity lines ignored");
        key(1, 0, 1, "R3 gap unlock");
        key(1, 0, 1, "R10 key during accept");
        check("R10 back in idle");
    endtask

    task automatic t_wrong_first();
        key(1, 1, 0, "R4 wrong first A");
        gap(2, 1, 0, "R2 bad path hold");
        key(1, 0, 1, "R4 second key");
        key(1, 0, 1, "R4 third key idle");
    endtask

    task automatic t_wrong_second();
        key(1, 0, 1, "R5 first B");
        key(1, 0, 1, "R5 wrong second B");
        key(1, 1, 0, "R5 third key idle");
    endtask

    task automatic t_wrong_third();
        key(1, 0, 1, "R6 first B");
        key(1, 1, 0, "R6 second A");
        key(1, 1, 0, "R6 wrong third A");
        gap(1, 0, 0, "R6 stays idle");
    endtask

    task automatic t_undefined();
        key(1, 0, 0, "R7 code 100 first");
        key(1, 1, 1, "R7 code 111 second");
        key(1, 0, 1, "R7 third");
        key(1, 0, 1, "R7 B");
        key(1, 1, 1, "R7 code 111 as second");
        key(1, 0, 0, "R7 code 100 third");
        key(1, 0, 1, "R7 B again");
        key(1, 1, 0, "R7 A");
        key(1, 0, 0, "R7 code 100 wrong third");
    endtask

    task automatic t_reset_mid();
        key(1, 0, 1, "R1 pre-reset B");
        key(1, 1, 0, "R1 pre-reset A");
        t_reset();
        key(1, 0, 1, "R8 count one line");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_good_back_to_back();
        t_good_with_gaps();
        t_wrong_first();
        t_wrong_second();
        t_wrong_third();
        t_undefined();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule